// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is one timer channel that software programs through a small register bus. A mode register selects the channel's function and holds the run, repeat and interrupt-enable controls. A count register packs two sixteen-bit fields. The lower field is the period length. The upper field is a clock divider. When the channel is set to interval mode and armed, the bus clock is divided by the prescaler, and the divided ticks are counted until the period length is reached. Each completed period sets a sticky status flag, and that flag can drive an interrupt line.

Both fields are one-based: a value of N divides or counts by N. A value of zero stands for 65536. In one-shot operation the channel disarms itself after the first period. In repeat operation it starts again from zero and keeps running. Rewriting the count register while the channel runs restarts both stages. The mode register can also drive the channel's pin as a plain output level.

Top module: `interval_timer`

## Requirements
- R1: After reset, the mode, count and status registers all read 0. The `irq` output is 0 and `pin_oe` is 0.
- R2: A period ends P*R bus-clock cycles after the write that arms the channel. Arming means the mode register has bit 12 set and bits 2:0 equal to 4. P is count[31:16] and R is count[15:0], and a zero in either field counts as 65536. The end of a period sets status bit 0.
- R3: A prescaler field of 0 divides the clock by 65536. With R=1, the period ends 65536 cycles after arming.
- R4: When mode bit 10 is 0 (one-shot), the hardware clears mode bit 12 at the end of the first period, and no further period ends.
- R5: When mode bit 10 is 1 (repeat), the period counter returns to zero at each end of period and mode bit 12 stays set. The next period ends P*R cycles after the previous one.
- R6: If mode bit 12 is 0, or mode bits 2:0 are not 4, no period ends. After such a stop, re-arming counts a full period from zero.
- R7: A write to the count register while the channel runs restarts both stages. The next period ends P*R cycles after that write.
- R8: Status bit 0 stays set until a write to address 2 with bit 0 of the data equal to 1. Writing 0 to that bit leaves the flag unchanged. If a period ends in the same cycle as a clearing write, the flag stays set.
- R9: `irq` equals status bit 0 ANDed with mode bit 8.
- R10: When mode bit 5 is 1, `pin_oe` is 1 and `pin_out` follows mode bit 4. When mode bit 5 is 0, `pin_oe` is 0.
- R11: `reg_rdata` shows the register selected by `reg_addr` in the same cycle: 0 is mode, 1 is count, 2 is status, and 3 reads as zero. Written values read back unchanged unless R4 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, which also drives the timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Level driven on the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with its default widths of sixteen bits for the prescaler and sixteen bits for the period. This keeps the count register fields at the same bit positions software uses. With these widths, the zero-means-65536 prescaler case finishes in about 65 thousand cycles with a period of one, so the one-based wrap is checked directly rather than at a scaled-down width. Short combinations of prescaler and period then cover the product rule, restart-on-rewrite, repeat timing, stopping, and interrupt masking.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    ADDR_MODE  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_RSVD  = 2'd3
  } itmr_addr_e;

  localparam int SEL_LSB   = 0;
  localparam int SEL_W     = 3;
  localparam logic [SEL_W-1:0] SEL_INTERVAL = 3'd4;
  localparam int PIN_LVL   = 4;
  localparam int PIN_DRV   = 5;
  localparam int IRQ_EN    = 8;
  localparam int REPEAT    = 10;
  localparam int RUN       = 12;
  localparam int FLAG_BIT  = 0;
endpackage

// File: rtl/itmr_modcnt.sv
module itmr_modcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic [W-1:0] last;

  // one-based limit: zero wraps to all ones, meaning 2**W steps
  assign last = limit - ONE;
  assign hit  = adv && (cnt_q == last);

  always_comb begin
    cnt_en = clr || adv;
    if (clr || hit) cnt_d = '0;
    else            cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [1:0]                 reg_addr,
  input  logic [PRESC_W+CNT_W-1:0]   reg_wdata,
  input  logic                       expire,
  output logic [PRESC_W+CNT_W-1:0]   mode_q,
  output logic [PRESC_W+CNT_W-1:0]   count_q,
  output logic                       flag_q,
  output logic                       count_wr,
  output logic [PRESC_W+CNT_W-1:0]   reg_rdata
);
  localparam int BUS_W = PRESC_W + CNT_W;

  logic             mode_wr;
  logic             stat_clr;
  logic             mode_en;
  logic             flag_en;
  logic [BUS_W-1:0] mode_d;
  logic             flag_d;

  always_comb begin
    mode_wr  = reg_we && (itmr_addr_e'(reg_addr) == ADDR_MODE);
    count_wr = reg_we && (itmr_addr_e'(reg_addr) == ADDR_COUNT);
    stat_clr = reg_we && (itmr_addr_e'(reg_addr) == ADDR_STAT) && reg_wdata[FLAG_BIT];

    mode_d  = mode_q;
    mode_en = 1'b0;
    if (mode_wr) begin
      mode_d  = reg_wdata;
      mode_en = 1'b1;
    end else if (expire && !mode_q[REPEAT]) begin
      mode_d[RUN] = 1'b0;
      mode_en     = 1'b1;
    end

    // a period ending wins over a clear in the same cycle
    flag_en = expire || stat_clr;
    flag_d  = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_wr) count_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_comb begin
    case (itmr_addr_e'(reg_addr))
      ADDR_MODE:  reg_rdata = mode_q;
      ADDR_COUNT: reg_rdata = count_q;
      ADDR_STAT:  reg_rdata = {{(BUS_W-1){1'b0}}, flag_q};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [1:0]               reg_addr,
  input  logic [PRESC_W+CNT_W-1:0] reg_wdata,
  output logic [PRESC_W+CNT_W-1:0] reg_rdata,
  output logic                     irq,
  output logic                     pin_out,
  output logic                     pin_oe
);
  localparam int BUS_W = PRESC_W + CNT_W;

  logic [BUS_W-1:0] mode_q;
  logic [BUS_W-1:0] count_q;
  logic             flag_q;
  logic             count_wr;
  logic             running;
  logic             stage_clr;
  logic             pre_adv;
  logic             tick;
  logic             expire;

  itmr_regfile #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .expire    (expire),
    .mode_q    (mode_q),
    .count_q   (count_q),
    .flag_q    (flag_q),
    .count_wr  (count_wr),
    .reg_rdata (reg_rdata)
  );

  always_comb begin
    running   = mode_q[RUN] && (mode_q[SEL_LSB +: SEL_W] == SEL_INTERVAL);
    stage_clr = !running || count_wr;
    pre_adv   = running && !count_wr;
  end

  itmr_modcnt #(.W(PRESC_W)) presc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stage_clr),
    .adv   (pre_adv),
    .limit (count_q[CNT_W +: PRESC_W]),
    .hit   (tick)
  );

  itmr_modcnt #(.W(CNT_W)) period_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stage_clr),
    .adv   (tick),
    .limit (count_q[CNT_W-1:0]),
    .hit   (expire)
  );

  assign irq     = flag_q && mode_q[IRQ_EN];
  assign pin_oe  = mode_q[PIN_DRV];
  assign pin_out = mode_q[PIN_DRV] && mode_q[PIN_LVL];
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
  import itmr_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [BUS_W-1:0] reg_wdata,
  input logic [BUS_W-1:0] mode_q,
  input logic             flag_q,
  input logic             expire,
  input logic             running,
  input logic             irq
);
  logic mode_wr;
  logic stat_clr;
  assign mode_wr  = reg_we && (reg_addr == 2'd0);
  assign stat_clr = reg_we && (reg_addr == 2'd2) && reg_wdata[FLAG_BIT];

  assert_flag_from_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire));

  assert_oneshot_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q[REPEAT] && !mode_wr) |=> !mode_q[RUN]);

  assert_repeat_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode_q[REPEAT] && !mode_wr) |=> mode_q[RUN]);

  assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !expire);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_clr) |=> flag_q);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[IRQ_EN] |-> !irq);
endmodule

bind interval_timer itmr_chk #(.BUS_W(PRESC_W + CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mode_q    (mode_q),
  .flag_q    (flag_q),
  .expire    (expire),
  .running   (running),
  .irq       (irq)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        pin_out;
  logic        pin_oe;

  int n_chk;
  int n_fail;
  bit done;

  // mode encodings: run=bit12, repeat=bit10, irq enable=bit8, select=bits2:0 (4 = interval)
  localparam logic [31:0] M_ONESHOT = 32'h0000_1104;
  localparam logic [31:0] M_REPEAT  = 32'h0000_1504;
  localparam logic [31:0] M_NOIRQ   = 32'h0000_1004;

  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0001_0001, 32'h0001_0005, 32'h0003_0004,
    32'h0007_0002, 32'h0002_0010, 32'h0005_0003
  };

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int period_of(input logic [31:0] c);
    int p;
    int r;
    p = (c[31:16] == 16'd0) ? 65536 : int'(c[31:16]);
    r = (c[15:0]  == 16'd0) ? 65536 : int'(c[15:0]);
    return p * r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 2'd2;
    #1;
  endtask

  // cycles after the last write edge until status bit 0 reads 1; 0 if never
  task automatic wait_flag(input int max, output int n);
    n = 0;
    for (int k = 1; k <= max; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (reg_rdata[0]) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd2; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 mode", v, 0);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd2, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 pin_oe", pin_oe, 0);

    // R2 R4 R6 R9 vector walk: each entry starts from a stopped channel
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd1, VEC[i]);
      wr(2'd0, M_ONESHOT);
      wait_flag(2000, n);
      check("R2 period", n, period_of(VEC[i]));
      check("R9 irq set", irq, 1);
      rd(2'd0, v); check("R4 run cleared", v[12], 0);
      wr(2'd2, 32'h1);
      check("R8 cleared", reg_rdata[0], 0);
      check("R9 irq cleared", irq, 0);
      wait_flag(3 * period_of(VEC[i]), n);
      check("R4 no second expiry", n, 0);
    end

    // R11 readback and reserved address
    wr(2'd1, 32'hA5A5_5A5A);
    rd(2'd1, v); check("R11 count readback", v, 32'hA5A5_5A5A);
    rd(2'd3, v); check("R11 reserved zero", v, 0);
    wr(2'd0, 32'h0000_0400);
    rd(2'd0, v); check("R11 mode readback", v, 32'h0000_0400);

    // R10 pin drive
    wr(2'd0, 32'h0000_0030);
    check("R10 oe high", pin_oe, 1); check("R10 level high", pin_out, 1);
    wr(2'd0, 32'h0000_0020);
    check("R10 oe low-drive", pin_oe, 1); check("R10 level low", pin_out, 0);
    wr(2'd0, 32'h0000_0010);
    check("R10 no drive", pin_oe, 0);

    // R5 repeat: second period P*R after the first (one cycle spent clearing)
    wr(2'd1, 32'h0002_0003);
    wr(2'd0, M_REPEAT);
    wait_flag(100, n); check("R5 first", n, 6);
    wr(2'd2, 32'h1);
    wait_flag(100, n); check("R5 second", n, 5);
    rd(2'd0, v); check("R5 run stays", v[12], 1);

    // R6 stop by clearing run
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h1);
    wait_flag(50, n); check("R6 stopped", n, 0);
    // R6 wrong select
    wr(2'd0, 32'h0000_1002);
    wait_flag(50, n); check("R6 select 2 idle", n, 0);

    // R7 rewrite count mid-run restarts
    wr(2'd1, 32'h0001_000A);
    wr(2'd0, M_ONESHOT);
    repeat (4) @(posedge clk);
    @(negedge clk);
    wr(2'd1, 32'h0001_000A);
    wait_flag(100, n); check("R7 restart", n, 10);
    wr(2'd2, 32'h1);

    // R8 writing zero keeps flag; R9 masked irq
    wr(2'd1, 32'h0001_0002);
    wr(2'd0, M_NOIRQ);
    wait_flag(50, n); check("R9 masked run", n, 2);
    check("R9 irq masked", irq, 0);
    wr(2'd2, 32'h0);
    check("R8 zero write keeps", reg_rdata[0], 1);
    wr(2'd2, 32'h1);

    // R3 prescaler zero divides by 65536
    wr(2'd1, 32'h0000_0001);
    wr(2'd0, M_ONESHOT);
    wait_flag(70000, n); check("R3 prescale zero", n, 65536);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule